// File: doc/BRIEF.md
# I2C Byte Master with Pending-Flag Handshake

This block is an I2C bus master that software steers one byte at a time through four 8-bit registers. A write to the status register starts a transfer. A START condition goes out, followed by the byte that software left in the data register, which holds the target address and the direction bit. After each byte and its acknowledge slot, the block sets a pending flag and holds SCL low. It leaves the bus frozen until software writes 0 to that flag. Before releasing the flag, software loads the next byte to send, reads the byte just received, picks the ACK or NACK answer for the next received byte, or queues a STOP or a repeated START.

The serial clock comes from the system clock in two stages. A prescale of 16 or 512 is chosen by one control bit. A divide-by-(divisor+1) stage follows it, with the divisor taken from a 4-bit field. The block works in quarter-period steps. SDA changes only while SCL is low, and SDA is sampled at the midpoint of the SCL high phase. Both lines are open-drain: each output pin is a pull-low enable, and each line is read back through a two-flop synchronizer. A target that holds SCL low stretches the high phase of a data bit.

Register offsets: 0 is control, 1 is status, 2 is data, 3 is the own-address register. Reads are combinational and have no side effects. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, all four registers read 0, `irq` is 0, status bit 5 (busy) is 0, and both `scl_oe` and `sda_oe` are 0 (lines released). Whenever busy is 0, both lines stay released.
- R2: One SCL period lasts P*(D+1) system clocks. D is control bits 3:0. P is 512 when control bit 6 is 1 and 16 when it is 0.
- R3: Writing status with bits 7, 5 and 4 set while busy is 0 does three things. It produces a START (SDA falls while SCL is high), shifts out the data register MSB first, and sets busy (status bit 5 on read) from the next clock.
- R4: At the end of the ninth SCL pulse of a byte, control bit 4 (pending) is set and SCL is held low until software writes 0 to bit 4. Writing 1 to bit 4 leaves it unchanged.
- R5: Status bit 0 reads back the SDA level sampled in the last acknowledge slot (1 means NACK).
- R6: The first byte after a START or repeated START is always transmitted. Later bytes are received when status bits 7:6 are 10 and transmitted when they are 11. A received byte is in the data register when pending rises. During its acknowledge slot the master pulls SDA low if control bit 7 is 1 and releases SDA if it is 0.
- R7: Writing status with bit 7 and bit 4 set and bit 5 clear while busy queues a STOP, which is issued once pending is 0. SCL is released first, and SDA is released half an SCL period later. Busy then clears with both lines released.
- R8: Writing status with bits 7, 5 and 4 set while busy queues a repeated START, which is issued once pending is 0 with no STOP in between. The data register byte is then sent.
- R9: `irq` is high exactly when pending and control bit 5 are both 1.
- R10: Within a byte, SDA never changes while SCL is high. The only SDA edges during SCL high are the START, repeated START and STOP that software requested.
- R11: The own-address register at offset 3 stores any written value and reads it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt: pending and enabled |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA line level |

## Verification
Register writes and the pending-flag clear are seen one clock edge after the write strobe. Busy is therefore checked on the cycle after the START write, and a pending clear releases SCL on the following edge. Pending and `irq` rise on the same edge that ends the ninth SCL pulse. That edge lies a data-dependent number of quarter periods away, so the bench polls pending through the control register instead of counting cycles to it. Line timing is measured exactly: a model target stamps every SCL and SDA rise with the cycle count. The bench compares the last two SCL rises of a byte against P*(D+1), and the gap from the STOP SCL rise to the SDA rise against P*(D+1)/2.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_START,
    ENG_BIT,
    ENG_HOLD,
    ENG_STOP
  } eng_state_t;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_STAT = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;
  localparam logic [1:0] RA_OWN  = 2'd3;

  localparam logic [1:0] MODE_MRX = 2'b10;

  // control field positions
  localparam int CB_ACK  = 7;
  localparam int CB_PRE  = 6;
  localparam int CB_IE   = 5;
  localparam int CB_PEND = 4;

  // status field positions
  localparam int SB_MASTER = 7;
  localparam int SB_STST   = 5;
  localparam int SB_TXEN   = 4;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_flops
      logic [WIDTH-1:0] r [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) r[i] <= '1;
        end else begin
          r[0] <= d;
          for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
        end
      end
      assign q = r[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2cm_clkgen.sv
module i2cm_clkgen #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512,
  parameter int DIV_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pre_sel,
  input  logic [DIV_W-1:0] div,
  output logic             qtick
);
  localparam int QLO = PRE_LO / 4;
  localparam int QHI = PRE_HI / 4;
  localparam int PW  = $clog2(QHI + 1);

  logic [PW-1:0]    pre_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic [PW-1:0]    lim;
  logic             pre_wrap, div_wrap;

  assign lim      = pre_sel ? PW'(QHI) : PW'(QLO);
  assign pre_wrap = (pre_cnt == lim - PW'(1));
  assign div_wrap = (div_cnt == div);
  assign qtick    = run && pre_wrap && div_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (!run) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt <= '0;
      div_cnt <= div_wrap ? '0 : div_cnt + DIV_W'(1);
    end else begin
      pre_cnt <= pre_cnt + PW'(1);
    end
  end
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             busy,
  input  logic             byte_done,
  input  logic             rx_load,
  input  logic [DW-1:0]    rx_byte,
  input  logic             nack_in,
  input  logic             req_taken,
  output logic             go_start,
  output logic             stop_req,
  output logic             rs_req,
  output logic             pending,
  output logic             ack_en,
  output logic             pre_sel,
  output logic [DIV_W-1:0] div,
  output logic             mode_rx,
  output logic [DW-1:0]    tx_byte,
  output logic             irq
);
  logic          ie_q, txen_q, nack_q;
  logic [1:0]    mode_q;
  logic [DW-1:0] data_q, own_q;
  logic          wr_ctrl, wr_stat, cmd_ok;

  assign wr_ctrl = wr && (addr == RA_CTRL);
  assign wr_stat = wr && (addr == RA_STAT);
  assign cmd_ok  = wdata[SB_MASTER] && wdata[SB_TXEN];

  assign go_start = wr_stat && cmd_ok && wdata[SB_STST] && !busy;
  assign mode_rx  = (mode_q == MODE_MRX);
  assign tx_byte  = data_q;
  assign irq      = pending && ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_en   <= 1'b0;
      pre_sel  <= 1'b0;
      ie_q     <= 1'b0;
      pending  <= 1'b0;
      div      <= '0;
      mode_q   <= 2'b00;
      txen_q   <= 1'b0;
      nack_q   <= 1'b0;
      data_q   <= '0;
      own_q    <= '0;
      stop_req <= 1'b0;
      rs_req   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ack_en  <= wdata[CB_ACK];
        pre_sel <= wdata[CB_PRE];
        ie_q    <= wdata[CB_IE];
        div     <= wdata[DIV_W-1:0];
        pending <= pending & wdata[CB_PEND];
      end
      if (wr_stat) begin
        mode_q <= wdata[7:6];
        txen_q <= wdata[SB_TXEN];
      end
      if (wr && addr == RA_DATA) data_q <= wdata;
      if (wr && addr == RA_OWN)  own_q  <= wdata;

      if (req_taken) begin
        stop_req <= 1'b0;
        rs_req   <= 1'b0;
      end
      if (wr_stat && cmd_ok && busy) begin
        stop_req <= !wdata[SB_STST];
        rs_req   <= wdata[SB_STST];
      end

      if (byte_done) begin
        pending <= 1'b1;
        nack_q  <= nack_in;
        if (rx_load) data_q <= rx_byte;
      end
    end
  end

  always_comb begin
    unique case (addr)
      RA_CTRL: rdata = {ack_en, pre_sel, ie_q, pending, {(4-DIV_W){1'b0}}, div};
      RA_STAT: rdata = {mode_q, busy, txen_q, 3'b000, nack_q};
      RA_DATA: rdata = data_q;
      default: rdata = own_q;
    endcase
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          qtick,
  input  logic          go_start,
  input  logic          stop_req,
  input  logic          rs_req,
  input  logic          pending,
  input  logic          mode_rx,
  input  logic          ack_en,
  input  logic [DW-1:0] tx_byte,
  input  logic          scl_s,
  input  logic          sda_s,
  output logic          run,
  output logic          busy,
  output logic          in_bit,
  output logic          byte_done,
  output logic          rx_load,
  output logic [DW-1:0] rx_byte,
  output logic          nack,
  output logic          req_taken,
  output logic          scl_oe,
  output logic          sda_oe
);
  localparam int BW = $clog2(DW + 1);

  eng_state_t    state_q;
  logic [1:0]    ph_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] shift_q;
  logic          tx_q, scl_q, sda_q, busy_q, nack_q;
  logic          stretched, step, last_slot;

  assign run       = (state_q != ENG_IDLE) && (state_q != ENG_HOLD);
  assign stretched = (state_q == ENG_BIT) && (ph_q == 2'd1) && !scl_s;
  assign step      = qtick && !stretched;
  assign last_slot = (bit_q == BW'(DW));
  assign byte_done = (state_q == ENG_BIT) && step && (ph_q == 2'd3) && last_slot;
  assign rx_load   = byte_done && !tx_q;
  assign rx_byte   = shift_q;
  assign nack      = nack_q;
  assign req_taken = (state_q == ENG_HOLD) && !pending && (stop_req || rs_req);
  assign busy      = busy_q;
  assign in_bit    = (state_q == ENG_BIT);
  assign scl_oe    = scl_q;
  assign sda_oe    = sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      ph_q    <= 2'd0;
      bit_q   <= '0;
      shift_q <= '0;
      tx_q    <= 1'b0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      busy_q  <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ENG_IDLE: begin
          if (go_start) begin
            state_q <= ENG_START;
            ph_q    <= 2'd1;
            busy_q  <= 1'b1;
          end
        end
        ENG_START: if (step) begin
          ph_q <= ph_q + 2'd1;
          unique case (ph_q)
            2'd0: scl_q <= 1'b0;
            2'd1: sda_q <= 1'b1;
            2'd2: scl_q <= 1'b1;
            default: begin
              state_q <= ENG_BIT;
              bit_q   <= '0;
              shift_q <= tx_byte;
              tx_q    <= 1'b1;
              sda_q   <= !tx_byte[DW-1];
            end
          endcase
        end
        ENG_BIT: if (step) begin
          ph_q <= ph_q + 2'd1;
          unique case (ph_q)
            2'd0: scl_q <= 1'b0;
            2'd1: begin
              if (last_slot) nack_q <= sda_s;
              else           shift_q <= {shift_q[DW-2:0], sda_s};
            end
            2'd2: scl_q <= 1'b1;
            default: begin
              if (last_slot) begin
                state_q <= ENG_HOLD;
                sda_q   <= 1'b0;
              end else begin
                bit_q <= bit_q + BW'(1);
                if (bit_q == BW'(DW - 1)) sda_q <= tx_q ? 1'b0 : ack_en;
                else                      sda_q <= tx_q && !shift_q[DW-1];
              end
            end
          endcase
        end
        ENG_HOLD: begin
          if (!pending) begin
            ph_q <= 2'd0;
            if (stop_req) begin
              state_q <= ENG_STOP;
              sda_q   <= 1'b1;
            end else if (rs_req) begin
              state_q <= ENG_START;
              sda_q   <= 1'b0;
            end else begin
              state_q <= ENG_BIT;
              bit_q   <= '0;
              shift_q <= tx_byte;
              tx_q    <= !mode_rx;
              sda_q   <= !mode_rx && !tx_byte[DW-1];
            end
          end
        end
        ENG_STOP: if (step) begin
          ph_q <= ph_q + 2'd1;
          unique case (ph_q)
            2'd0: scl_q <= 1'b0;
            2'd1: ;
            2'd2: sda_q <= 1'b0;
            default: begin
              state_q <= ENG_IDLE;
              busy_q  <= 1'b0;
            end
          endcase
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int PRE_LO      = 16,
  parameter int PRE_HI      = 512,
  parameter int DIV_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int DW = 8;

  logic [1:0]       line_s;
  logic             qtick, run, busy, in_bit, byte_done, rx_load, nack;
  logic             req_taken, go_start, stop_req, rs_req, pending;
  logic             ack_en, pre_sel, mode_rx;
  logic [DIV_W-1:0] div;
  logic [DW-1:0]    rx_byte, tx_byte;

  i2cm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
  );

  i2cm_clkgen #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(pre_sel), .div(div),
    .qtick(qtick)
  );

  i2cm_regs #(.DW(DW), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy),
    .byte_done(byte_done), .rx_load(rx_load), .rx_byte(rx_byte),
    .nack_in(nack), .req_taken(req_taken), .go_start(go_start),
    .stop_req(stop_req), .rs_req(rs_req), .pending(pending),
    .ack_en(ack_en), .pre_sel(pre_sel), .div(div), .mode_rx(mode_rx),
    .tx_byte(tx_byte), .irq(irq)
  );

  i2cm_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .qtick(qtick), .go_start(go_start),
    .stop_req(stop_req), .rs_req(rs_req), .pending(pending),
    .mode_rx(mode_rx), .ack_en(ack_en), .tx_byte(tx_byte),
    .scl_s(line_s[1]), .sda_s(line_s[0]), .run(run), .busy(busy),
    .in_bit(in_bit), .byte_done(byte_done), .rx_load(rx_load),
    .rx_byte(rx_byte), .nack(nack), .req_taken(req_taken),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic irq,
  input logic busy,
  input logic pending,
  input logic in_bit,
  input logic go_start
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_start_sets_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go_start |=> busy);

  assert_hold_scl_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> scl_oe);

  assert_busy_falls_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (!scl_oe && !sda_oe));

  assert_irq_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pending);

  assert_sda_quiet_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bit && $past(in_bit) && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));
endmodule

bind i2c_byte_master i2cm_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
  .busy(busy), .pending(pending), .in_bit(in_bit), .go_start(go_start)
);

// File: tb/test_i2c_byte_master.sv
module test_i2c_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, scl_oe, sda_oe;
  logic       s_drive = 1'b0;
  wire        scl_line = !scl_oe;
  wire        sda_line = !(sda_oe || s_drive);

  i2c_byte_master i_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .scl_in(scl_line), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  always #2 clk = !clk;

  int cyc = 0, n_checks = 0, n_fail = 0;
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 190000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<190000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // ---------------- model target on the bus ----------------
  logic       slave_nack = 1'b0;
  logic [7:0] s_tx [4];
  logic [7:0] s_log [32];
  int         s_nlog = 0, n_start = 0, n_stop = 0;
  int         t_last = 0, t_prev = 0, t_sda_rise = 0;
  int         s_bit = -1, s_tidx = 0;
  logic       s_active = 1'b0, s_first = 1'b0, s_rd = 1'b0, s_mack = 1'b0;
  logic [7:0] s_byte = 8'd0;

  always @(negedge sda_line) if (scl_line) begin
    n_start++; s_active = 1; s_bit = -1; s_first = 1; s_rd = 0;
    s_drive = 0; s_byte = 0; s_tidx = 0;
  end
  always @(posedge sda_line) if (scl_line) begin
    n_stop++; s_active = 0; s_drive = 0; t_sda_rise = cyc;
  end
  always @(posedge scl_line) begin
    t_prev = t_last; t_last = cyc;
    if (s_active) begin
      if (s_bit >= 0 && s_bit <= 7) s_byte = {s_byte[6:0], sda_line};
      else if (s_bit == 8) s_mack = sda_line;
    end
  end
  always @(negedge scl_line) if (s_active) begin
    if (s_bit == -1) s_bit = 0;
    else if (s_bit < 7) begin
      s_bit++;
      if (s_rd && !s_first) s_drive = !s_tx[s_tidx][7 - s_bit];
    end else if (s_bit == 7) begin
      s_bit = 8;
      if (s_first) s_rd = s_byte[0];
      if (s_first || !s_rd) begin
        s_log[s_nlog % 32] = s_byte; s_nlog++; s_drive = !slave_nack;
      end else s_drive = 0;
    end else begin
      s_bit = 0;
      if (s_rd && !s_first) begin
        s_tidx++;
        if (s_mack) begin s_active = 0; s_drive = 0; end
        else s_drive = !s_tx[s_tidx][7];
      end else if (s_rd) s_drive = !s_tx[s_tidx][7];
      else s_drive = 0;
      s_first = 0;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_pend(input string req);
    logic [7:0] v;
    for (int i = 0; i < 40000; i++) begin
      rd(2'd0, v);
      if (v[4]) return;
    end
    chk(0, req, 0, 1);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] v;
    for (int i = 0; i < 40000; i++) begin
      rd(2'd1, v);
      if (!v[5]) return;
    end
    chk(0, req, 1, 0);
  endtask

  // {div, prescale select, address byte, data byte, target NACKs}
  localparam logic [21:0] VEC [4] = '{
    {4'd0, 1'b0, 8'hA0, 8'h5A, 1'b0},
    {4'd3, 1'b0, 8'h42, 8'hC3, 1'b0},
    {4'd1, 1'b1, 8'h7E, 8'h01, 1'b0},
    {4'd0, 1'b0, 8'h30, 8'hFF, 1'b1}
  };

  initial begin
    logic [7:0] v;
    int base, st0, sp0, per;
    s_tx[0] = 8'hB6; s_tx[1] = 8'h3C; s_tx[2] = 8'h00; s_tx[3] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk(v == 8'h00, "R1", v, 0);
    end
    chk(irq == 0, "R1", irq, 0);
    chk(scl_line && sda_line, "R1", {scl_line, sda_line}, 3);
    rst_n = 1;
    repeat (2) @(negedge clk);
    rd(2'd1, v); chk(v[5] == 0, "R1", v[5], 0);
    // R11 own address
    wr(2'd3, 8'h5C); rd(2'd3, v); chk(v == 8'h5C, "R11", v, 8'h5C);

    // table-driven write transfers
    foreach (VEC[k]) begin
      logic [3:0] dv; logic ps, nk; logic [7:0] ad, da;
      {dv, ps, ad, da, nk} = VEC[k];
      per = (ps ? 512 : 16) * (dv + 1);
      slave_nack = nk;
      wr(2'd0, {1'b1, ps, 2'b00, dv});
      wr(2'd2, ad);
      base = s_nlog; st0 = n_start; sp0 = n_stop;
      wr(2'd1, 8'hF0);
      rd(2'd1, v); chk(v[5] == 1, "R3 busy", v[5], 1);
      wait_pend("R4 pending");
      chk(s_log[base % 32] == ad, "R3 address", s_log[base % 32], ad);
      rd(2'd1, v); chk(v[0] == nk, "R5 ack bit", v[0], nk);
      chk(t_last - t_prev == per, "R2 period", t_last - t_prev, per);
      repeat (20) @(negedge clk);
      chk(scl_line == 0, "R4 scl held", scl_line, 0);
      wr(2'd2, da);
      wr(2'd0, {1'b1, ps, 2'b00, dv});
      wait_pend("R4 pending");
      chk(s_log[(base + 1) % 32] == da, "R4 data", s_log[(base + 1) % 32], da);
      wr(2'd1, 8'hD0);
      wr(2'd0, {1'b1, ps, 2'b00, dv});
      wait_idle("R7 idle");
      chk(n_stop == sp0 + 1, "R7 stop", n_stop - sp0, 1);
      chk(n_start == st0 + 1, "R10 edges", n_start - st0, 1);
      chk(t_sda_rise - t_last == per / 2, "R7 half period", t_sda_rise - t_last, per / 2);
      chk(scl_line && sda_line, "R7 released", {scl_line, sda_line}, 3);
    end
    slave_nack = 0;

    // read transfer: ACK then NACK
    wr(2'd0, 8'h81);
    wr(2'd2, 8'h91);
    sp0 = n_stop;
    wr(2'd1, 8'hB0);
    wait_pend("R6 pending");
    rd(2'd1, v); chk(v[0] == 0, "R5 ack", v[0], 0);
    wr(2'd0, 8'h81);
    wait_pend("R6 pending");
    rd(2'd2, v); chk(v == 8'hB6, "R6 rx byte", v, 8'hB6);
    chk(s_mack == 0, "R6 master ack", s_mack, 0);
    wr(2'd0, 8'h01);
    wait_pend("R6 pending");
    rd(2'd2, v); chk(v == 8'h3C, "R6 rx byte", v, 8'h3C);
    chk(s_mack == 1, "R6 master nack", s_mack, 1);
    rd(2'd1, v); chk(v[0] == 1, "R5 nack", v[0], 1);
    wr(2'd1, 8'h90);
    wr(2'd0, 8'h01);
    wait_idle("R7 idle");
    chk(n_stop == sp0 + 1, "R7 stop", n_stop - sp0, 1);

    // repeated start, with irq and pending-write checks during a hold
    wr(2'd0, 8'h80);
    wr(2'd2, 8'hA0);
    base = s_nlog; st0 = n_start; sp0 = n_stop;
    wr(2'd1, 8'hF0);
    wait_pend("R8 pending");
    wr(2'd0, 8'hB0);
    rd(2'd0, v); chk(v[4] == 1, "R4 write1 keeps", v[4], 1);
    chk(irq == 1, "R9 irq on", irq, 1);
    repeat (100) @(negedge clk);
    chk(scl_line == 0, "R4 scl held", scl_line, 0);
    wr(2'd0, 8'h90);
    chk(irq == 0, "R9 irq masked", irq, 0);
    wr(2'd2, 8'h10);
    wr(2'd0, 8'h80);
    wait_pend("R8 pending");
    wr(2'd2, 8'hA2);
    wr(2'd1, 8'hF0);
    wr(2'd0, 8'h80);
    wait_pend("R8 pending");
    chk(n_start == st0 + 2, "R8 restart", n_start - st0, 2);
    chk(n_stop == sp0, "R8 no stop", n_stop - sp0, 0);
    chk(s_log[(base + 2) % 32] == 8'hA2, "R8 address", s_log[(base + 2) % 32], 8'hA2);
    wr(2'd2, 8'h77);
    wr(2'd0, 8'h80);
    wait_pend("R8 pending");
    chk(s_log[(base + 3) % 32] == 8'h77, "R8 data", s_log[(base + 3) % 32], 8'h77);
    wr(2'd1, 8'hD0);
    wr(2'd0, 8'h80);
    wait_idle("R7 idle");
    chk(n_stop == sp0 + 1, "R10 edges", n_stop - sp0, 1);
    rd(2'd1, v); chk(v[5] == 0, "R7 busy", v[5], 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule